// File: doc/BRIEF.md
# Tiny Coherent Fully Associative Cachelet

This block is a very small cache that sits inside a coprocessor datapath and serves only the loads and stores that have been mapped to it. Every other access goes straight to the L1 cache and never reaches it. It holds between one and four lines. Each line carries one 32-bit word, the word address of that word as its tag, and a coherence state. Because the storage is this small, a hit finishes in the same cycle as the request, which is faster than a trip to L1.

Ownership is always exclusive. A line is in one of three states: Invalid, Exclusive (clean) or Modified (dirty). There is no shared state. The block never snoops the rest of the system; L1 keeps track of which lines have been handed out.

- **Datapath port.** Carries load and store requests.
- **L1 port, checkout side.** On a miss the block checks a line out from L1 and receives it with exclusive ownership.
- **L1 port, writeback side.** Before a victim is replaced, its dirty data is sent back to L1.
- **L1 port, shootdown side.** When L1 wants a line back it issues a shootdown. The block answers at once with the dirty data, if there is any, and drops the line.

All addresses on every port are word addresses.

Top module: `lineset_cache`

## Requirements
- R1: After reset every line is Invalid. No writeback or checkout request is raised. The first access to any address misses.
- R2: A load that hits raises `dp_ready` in the same cycle as the request and returns the stored word on `dp_rdata`.
- R3: A store that hits writes `dp_wdata` into the line in the same cycle it is acknowledged, and the line becomes Modified.
- R4: A miss raises `co_req` with `co_addr` equal to the requested word address. When `co_gnt` is seen, `co_data` is installed as an Exclusive line. The held request then completes as a hit in the next cycle.
- R5: Any line may hold any address, and an address is held in at most one line. A miss fills the lowest-numbered Invalid line, if one exists.
- R6: When every line is valid, the victim is chosen by a round-robin pointer. The pointer starts at line 0 after reset and advances by one, wrapping at `NLINES`, each time it supplies a victim.
- R7: A Modified victim is written back, with `wb_addr` and `wb_data` set to its tag and word, and the writeback is acknowledged by `wb_ack` before `co_req` is raised. An Exclusive victim is dropped without a writeback. At most one of `wb_req`, `co_req` and `dp_ready` is high in any cycle.
- R8: A shootdown is acknowledged on `sd_ack` in the cycle it is requested. If the address is held Modified, `sd_dirty` is 1 and `sd_data` carries the word. The line is Invalid from the next cycle, so the next access to it misses.
- R9: A shootdown takes priority over a datapath request in the same cycle. `dp_ready` stays low and the datapath request is retried afterwards.
- R10: A shootdown for an address that is not held is still acknowledged, with `sd_dirty` equal to 0, and no line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_req | input | 1 | Datapath access request, held until `dp_ready` |
| dp_we | input | 1 | 1 = store, 0 = load |
| dp_addr | input | AW | Word address of the access |
| dp_wdata | input | DW | Store data |
| dp_ready | output | 1 | Access completes this cycle |
| dp_rdata | output | DW | Load data, valid with `dp_ready` |
| co_req | output | 1 | Checkout request to L1 |
| co_addr | output | AW | Word address being checked out |
| co_gnt | input | 1 | L1 grants the checkout |
| co_data | input | DW | Word supplied with the grant |
| wb_req | output | 1 | Writeback of a Modified victim |
| wb_addr | output | AW | Word address written back |
| wb_data | output | DW | Word written back |
| wb_ack | input | 1 | L1 accepts the writeback |
| sd_req | input | 1 | Shootdown request from L1 |
| sd_addr | input | AW | Word address to shoot down |
| sd_ack | output | 1 | Shootdown answered this cycle |
| sd_dirty | output | 1 | The shot-down line was Modified |
| sd_data | output | DW | Word returned on a dirty shootdown |

## Verification
The bench runs a directed sequence followed by a sweep of about sixty accesses over six word addresses, which is more than the four lines can hold. Loads and stores are interleaved, and a reference model predicts every hit, miss, victim, writeback and returned word.

- Filling the lines one at a time separates lowest-free allocation from round-robin replacement.
- Evicting a clean victim and then a dirty one separates the silent drop from a writeback that must come before the checkout.
- Shootdowns are issued to a dirty line, to a clean line and to an absent line, with a datapath request pending. These separate the returned data, the dirty flag and the stall that comes from the shootdown's priority.

// File: rtl/lineset_cache.sv
module lineset_cache #(
  parameter int NLINES = 4,
  parameter int AW     = 16,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_req,
  input  logic          dp_we,
  input  logic [AW-1:0] dp_addr,
  input  logic [DW-1:0] dp_wdata,
  output logic          dp_ready,
  output logic [DW-1:0] dp_rdata,
  output logic          co_req,
  output logic [AW-1:0] co_addr,
  input  logic          co_gnt,
  input  logic [DW-1:0] co_data,
  output logic          wb_req,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  input  logic          wb_ack,
  input  logic          sd_req,
  input  logic [AW-1:0] sd_addr,
  output logic          sd_ack,
  output logic          sd_dirty,
  output logic [DW-1:0] sd_data
);
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_CO} state_t;

  state_t              state;
  logic [NLINES-1:0]   vld, dty;
  logic [AW-1:0]       tag [NLINES];
  logic [DW-1:0]       dat [NLINES];
  logic [NLINES-1:0]   dp_match, sd_match;
  logic [IW-1:0]       hidx, sidx, fidx, vsel, vic, rr;
  logic                has_free;
  logic [AW-1:0]       mtag;

  for (genvar i = 0; i < NLINES; i++) begin : g_cmp
    assign dp_match[i] = vld[i] && (tag[i] == dp_addr);
    assign sd_match[i] = vld[i] && (tag[i] == sd_addr);
  end

  always_comb begin
    hidx = '0; sidx = '0; fidx = '0; has_free = 1'b0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (dp_match[i]) hidx = IW'(i);
      if (sd_match[i]) sidx = IW'(i);
      if (!vld[i]) begin fidx = IW'(i); has_free = 1'b1; end
    end
  end

  assign vsel     = has_free ? fidx : rr;
  assign dp_ready = (state == S_IDLE) && !sd_req && dp_req && (|dp_match);
  assign dp_rdata = dat[hidx];
  assign sd_ack   = sd_req;
  assign sd_dirty = sd_req && (|(sd_match & dty));
  assign sd_data  = dat[sidx];
  assign wb_req   = (state == S_WB) && !sd_req;
  assign wb_addr  = tag[vic];
  assign wb_data  = dat[vic];
  assign co_req   = (state == S_CO);
  assign co_addr  = mtag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      vld   <= '0;
      dty   <= '0;
      rr    <= '0;
      vic   <= '0;
      mtag  <= '0;
    end else begin
      if (sd_req && (|sd_match)) begin
        vld[sidx] <= 1'b0;
        dty[sidx] <= 1'b0;
      end
      case (state)
        S_IDLE: if (!sd_req && dp_req) begin
          if (|dp_match) begin
            if (dp_we) begin
              dat[hidx] <= dp_wdata;
              dty[hidx] <= 1'b1;
            end
          end else begin
            vic  <= vsel;
            mtag <= dp_addr;
            if (!has_free) rr <= (rr == IW'(NLINES - 1)) ? '0 : rr + 1'b1;
            if (vld[vsel] && dty[vsel]) state <= S_WB;
            else begin
              vld[vsel] <= 1'b0;
              state     <= S_CO;
            end
          end
        end
        S_WB: begin
          if (sd_req) begin
            if (sd_match[vic]) state <= S_CO;
          end else if (wb_ack) begin
            vld[vic] <= 1'b0;
            dty[vic] <= 1'b0;
            state    <= S_CO;
          end
        end
        S_CO: if (co_gnt) begin
          vld[vic] <= 1'b1;
          dty[vic] <= 1'b0;
          tag[vic] <= mtag;
          dat[vic] <= co_data;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lineset_cache_chk.sv
module lineset_cache_chk #(
  parameter int NLINES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dp_ready,
  input logic              co_req,
  input logic              co_gnt,
  input logic              wb_req,
  input logic              sd_req,
  input logic              sd_dirty,
  input logic [NLINES-1:0] dp_match,
  input logic [NLINES-1:0] sd_match,
  input logic [NLINES-1:0] vld
);
  AST_SD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sd_req |-> !dp_ready && !wb_req); // R9
  AST_SD_ABSENT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_req && !(|sd_match)) |-> !sd_dirty); // R10
  AST_SD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_req && (|sd_match)) |=> ((vld & $past(sd_match)) == '0)); // R8
  AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dp_match)); // R5
  AST_ONE_L1_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({co_req, wb_req, dp_ready})); // R7
  AST_GNT_ENDS_CO: assert property (@(posedge clk) disable iff (!rst_n)
    (co_req && co_gnt) |=> !co_req); // R4
endmodule

bind lineset_cache lineset_cache_chk #(.NLINES(NLINES)) u_chk (.*);

// File: tb/lineset_cache_bench.sv
module lineset_cache_bench;
  localparam int NL = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dp_req = 0, dp_we = 0, co_gnt = 0, wb_ack = 0, sd_req = 0;
  logic [AW-1:0] dp_addr = '0, sd_addr = '0;
  logic [DW-1:0] dp_wdata = '0, co_data = '0;
  logic dp_ready, co_req, wb_req, sd_ack, sd_dirty;
  logic [DW-1:0] dp_rdata, wb_data, sd_data;
  logic [AW-1:0] co_addr, wb_addr;

  always #5 clk = ~clk;

  lineset_cache #(.NLINES(NL), .AW(AW), .DW(DW)) u_lineset_cache (.*);

  int nchk = 0, nfail = 0;
  bit            mv [NL];
  bit            mdt[NL];
  logic [AW-1:0] ma [NL];
  logic [DW-1:0] md [NL];
  int            rr = 0;

  function automatic logic [DW-1:0] memv(input logic [AW-1:0] a);
    return (DW'(a) * 32'h0000_9E37) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < NL; i++) if (mv[i] && ma[i] == a) return i;
    return -1;
  endfunction

  task automatic access(input logic [AW-1:0] a, input bit we, input logic [DW-1:0] wd);
    int h, v;
    bit exp_wb, exp_co, seen_wb, seen_co, done;
    logic [AW-1:0] ewa;
    logic [DW-1:0] ewd, erd;
    h = find(a); exp_wb = 0; exp_co = 0; ewa = '0; ewd = '0;
    if (h < 0) begin
      v = -1;
      for (int i = NL - 1; i >= 0; i--) if (!mv[i]) v = i;
      if (v < 0) begin v = rr; rr = (rr + 1) % NL; end
      if (mv[v] && mdt[v]) begin exp_wb = 1; ewa = ma[v]; ewd = md[v]; end
      exp_co = 1;
      mv[v] = 1; ma[v] = a; md[v] = memv(a); mdt[v] = 0; h = v;
    end
    erd = md[h];
    if (we) begin md[h] = wd; mdt[h] = 1; end
    @(negedge clk);
    dp_req = 1; dp_we = we; dp_addr = a; dp_wdata = wd;
    seen_wb = 0; seen_co = 0; done = 0;
    #1;
    while (!done) begin
      if (dp_ready) begin
        check(seen_co == exp_co, "R4 checkout on miss only", 64'(seen_co), 64'(exp_co));
        check(seen_wb == exp_wb, "R7 writeback of Modified victim", 64'(seen_wb), 64'(exp_wb));
        if (!we) check(dp_rdata == erd, "R2 load data", 64'(dp_rdata), 64'(erd));
        @(posedge clk); #1;
        dp_req = 0; done = 1;
      end else if (wb_req) begin
        check(exp_wb && !seen_co && !seen_wb, "R7 writeback ordering", 64'(seen_co), 64'(0));
        check(wb_addr == ewa, "R6 victim address", 64'(wb_addr), 64'(ewa));
        check(wb_data == ewd, "R3 written-back data", 64'(wb_data), 64'(ewd));
        seen_wb = 1; wb_ack = 1;
        @(posedge clk); #1; wb_ack = 0;
      end else if (co_req) begin
        check(!exp_wb || seen_wb, "R7 writeback before checkout", 64'(seen_wb), 64'(exp_wb));
        check(co_addr == a, "R4 checkout address", 64'(co_addr), 64'(a));
        seen_co = 1; co_gnt = 1; co_data = memv(a);
        @(posedge clk); #1; co_gnt = 0;
      end else begin
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic shoot(input logic [AW-1:0] a, input bit with_dp, input logic [AW-1:0] pa);
    int h;
    bit ed;
    h = find(a);
    ed = (h >= 0) && mdt[h];
    @(negedge clk);
    sd_req = 1; sd_addr = a;
    if (with_dp) begin dp_req = 1; dp_we = 0; dp_addr = pa; end
    #1;
    check(sd_ack == 1'b1, "R8 shootdown acknowledged", 64'(sd_ack), 64'(1));
    check(sd_dirty == ed, (h < 0) ? "R10 absent shootdown clean" : "R8 dirty flag", 64'(sd_dirty), 64'(ed));
    if (ed) check(sd_data == md[h], "R8 shootdown data", 64'(sd_data), 64'(md[h]));
    if (with_dp) check(dp_ready == 1'b0, "R9 shootdown priority", 64'(dp_ready), 64'(0));
    @(posedge clk); #1;
    sd_req = 0; dp_req = 0;
    if (h >= 0) begin mv[h] = 0; mdt[h] = 0; end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin mv[i] = 0; mdt[i] = 0; ma[i] = '0; md[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!co_req && !wb_req && !dp_ready, "R1 idle after reset", 64'({co_req, wb_req, dp_ready}), 64'(0));
    shoot(16'h0040, 0, '0);
    // R1 R5: first accesses miss and fill lines in order
    for (int k = 0; k < NL; k++) access(AW'(16'h0100 + k * 3), 0, '0);
    // R2: hits
    for (int k = NL - 1; k >= 0; k--) access(AW'(16'h0100 + k * 3), 0, '0);
    // R3: stores
    access(16'h0103, 1, 32'hDEAD_0001);
    access(16'h0109, 1, 32'hDEAD_0003);
    access(16'h0103, 0, '0);
    // R6 R7: clean victim then dirty victim
    access(16'h0200, 0, '0);
    access(16'h0201, 1, 32'hCAFE_0005);
    // R8 R9: dirty shootdown with pending access, clean one, absent one
    shoot(16'h0109, 1, 16'h0100);
    shoot(16'h0200, 1, 16'h0109);
    shoot(16'h0777, 0, '0);
    // R8: shot-down address misses and refills the freed line
    access(16'h0109, 0, '0);
    // Sweep
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      a = AW'(16'h0300 + ((i * 7) % 6) * 5);
      access(a, (i % 3) == 0, DW'(i) * 32'h0101_0101 + 32'd5);
      if (i % 9 == 4) shoot(AW'(16'h0300 + ((i * 5) % 6) * 5), 1, a);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule